// File: doc/BRIEF.md
# A20 Address Gate Controller

This block decides whether physical address bit 20 coming from the CPU side reaches memory. When the gate is closed, bit 20 is forced to zero. Any address between 1 MB and 1 MB + 64 KB then folds back onto the bottom of memory, as early real-mode software expects. When the gate is open, the full 24-bit (16 MB) space passes through unchanged.

Software opens the gate through either of two I/O-mapped paths, and the effective enable is the OR of the two. The first path is a single-write fast control byte at port 0x92, where bit 1 is the enable. The second path is a small model of a keyboard-controller command interface. A command byte goes to port 0x64, and port 0x60 carries data both ways. Software reads a controller output-port byte with one command and rewrites it with another; bit 1 of that byte is the second enable. Two status flags provide the handshake. An input-busy flag stays up for a fixed number of clocks after each accepted write. A data-ready flag is set when a byte waits to be read at port 0x60.

Top module: `a20_gate_ctrl`

## Requirements
- R1: After reset the gate is closed, the keyboard interface is enabled, the output port and the fast control byte are 0x00, and the status byte at 0x64 reads 0x10.
- R2: `mem_addr_o` equals `cpu_addr_i` combinationally, except that bit 20 is `cpu_addr_i[20] & a20_en_o`.
- R3: A write to port 0x92 stores the whole byte. It is accepted regardless of the busy flag and can be read back at 0x92. Its bit 1 enables the gate.
- R4: `a20_en_o` is the OR of fast-byte bit 1 and output-port bit 1.
- R5: Command 0xD0 at 0x64 copies the output port into the read buffer and sets status bit 0. A read of 0x60 returns that byte and clears status bit 0 on the same clock edge.
- R6: After command 0xD1, the next accepted write to 0x60 replaces the output port. A write to 0x60 without a pending 0xD1 leaves the output port unchanged.
- R7: Command 0xAD clears the keyboard-enable output and status bit 4, and command 0xAE sets them.
- R8: Each accepted write to 0x60 or 0x64 raises status bit 1 for exactly BUSY_CYCLES clocks.
- R9: A write to 0x60 or 0x64 made while status bit 1 is set is dropped and changes no state.
- R10: `io_rdata_o` is 0x00 when no read is strobed, and also for a read of any address other than 0x60, 0x64 or 0x92.
- R11: Any accepted command other than 0xD1 cancels a pending 0xD1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 16 | I/O address |
| io_wr_i | input | 1 | Write strobe, one clock per access |
| io_rd_i | input | 1 | Read strobe, one clock per access |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, combinational |
| cpu_addr_i | input | 24 | Physical address from the CPU side |
| mem_addr_o | output | 24 | Gated physical address |
| a20_en_o | output | 1 | Effective gate enable |
| kbd_en_o | output | 1 | Keyboard interface enable |

## Verification
The CPU address changes on every clock with a stride that toggles bit 20 often. Each gated output is compared against a behavioural model under four conditions: both sources off, fast byte only, output port only, and both on. This separates a wrong OR from a gate tied to one source. The command path runs in three ways. The first is the proper polled sequence. The second issues writes during the busy window, which shows whether dropped writes leak into state. The third sends stray data bytes and an intervening command between 0xD1 and its data, which shows whether the pending flag is kept or cleared correctly. Status reads at every busy count pin the exact length of the busy window.

// File: rtl/a20_pkg.sv
package a20_pkg;
  localparam logic [15:0] PORT_DATA = 16'h0060;
  localparam logic [15:0] PORT_CMD  = 16'h0064;
  localparam logic [15:0] PORT_FAST = 16'h0092;

  localparam logic [7:0] CMD_RD_OUT  = 8'hD0;
  localparam logic [7:0] CMD_WR_OUT  = 8'hD1;
  localparam logic [7:0] CMD_KBD_OFF = 8'hAD;
  localparam logic [7:0] CMD_KBD_ON  = 8'hAE;

  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_KBD = 4;
  localparam int EN_BIT = 1;
endpackage

// File: rtl/a20_fast_port.sv
module a20_fast_port #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] reg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      reg_o <= '0;
    else if (wr_en_i) reg_o <= wdata_i;
  end
endmodule

// File: rtl/a20_kbc.sv
module a20_kbc
  import a20_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_data_i,
  input  logic       wr_cmd_i,
  input  logic       rd_data_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] out_port_o,
  output logic [7:0] obuf_o,
  output logic       obf_o,
  output logic       ibf_o,
  output logic       kbd_en_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] BUSY_LOAD = CW'(BUSY_CYCLES);

  logic [CW-1:0] busy_q;
  logic          pend_q;
  logic          acc_cmd, acc_data;

  assign ibf_o    = (busy_q != '0);
  assign acc_cmd  = wr_cmd_i  && !ibf_o;
  assign acc_data = wr_data_i && !ibf_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= '0;
      pend_q     <= 1'b0;
      out_port_o <= 8'h00;
      obuf_o     <= 8'h00;
      obf_o      <= 1'b0;
      kbd_en_o   <= 1'b1;
    end else begin
      if (acc_cmd || acc_data) busy_q <= BUSY_LOAD;
      else if (ibf_o)          busy_q <= busy_q - 1'b1;

      if (rd_data_i) obf_o <= 1'b0;

      if (acc_cmd) begin
        pend_q <= (wdata_i == CMD_WR_OUT);
        unique case (wdata_i)
          CMD_RD_OUT: begin
            obuf_o <= out_port_o;
            obf_o  <= 1'b1;
          end
          CMD_KBD_OFF: kbd_en_o <= 1'b0;
          CMD_KBD_ON:  kbd_en_o <= 1'b1;
          default: ;
        endcase
      end else if (acc_data) begin
        if (pend_q) out_port_o <= wdata_i;
        pend_q <= 1'b0;
      end
    end
  end

  // R8
  ibf_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ibf_o) |-> $past(wr_cmd_i || wr_data_i));

  // R9
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ibf_o && (wr_data_i || wr_cmd_i)) |=> ($stable(out_port_o) && $stable(kbd_en_o)));

  // R5
  obf_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(obf_o) |-> $past(wr_cmd_i && wdata_i == CMD_RD_OUT));

  // R8
  busy_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q <= BUSY_LOAD);
endmodule

// File: rtl/a20_addr_gate.sv
module a20_addr_gate #(
  parameter int AW       = 24,
  parameter int GATE_BIT = 20
) (
  input  logic [AW-1:0] addr_i,
  input  logic          en_i,
  output logic [AW-1:0] addr_o
);
  for (genvar i = 0; i < AW; i++) begin : g_bit
    if (i == GATE_BIT) begin : g_gated
      assign addr_o[i] = addr_i[i] & en_i;
    end else begin : g_pass
      assign addr_o[i] = addr_i[i];
    end
  end
endmodule

// File: rtl/a20_gate_ctrl.sv
module a20_gate_ctrl
  import a20_pkg::*;
#(
  parameter int AW          = 24,
  parameter int IO_AW       = 16,
  parameter int BUSY_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic             io_wr_i,
  input  logic             io_rd_i,
  input  logic [7:0]       io_wdata_i,
  output logic [7:0]       io_rdata_o,
  input  logic [AW-1:0]    cpu_addr_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic             a20_en_o,
  output logic             kbd_en_o
);
  localparam int GATE_BIT = 20;

  logic       sel_data, sel_cmd, sel_fast;
  logic [7:0] fast_q, out_port, obuf;
  logic       obf, ibf;
  logic [7:0] status;

  assign sel_data = (io_addr_i == IO_AW'(PORT_DATA));
  assign sel_cmd  = (io_addr_i == IO_AW'(PORT_CMD));
  assign sel_fast = (io_addr_i == IO_AW'(PORT_FAST));

  a20_fast_port #(.DW(8)) u_fast (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (io_wr_i && sel_fast),
    .wdata_i (io_wdata_i),
    .reg_o   (fast_q)
  );

  a20_kbc #(.BUSY_CYCLES(BUSY_CYCLES)) u_kbc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_data_i  (io_wr_i && sel_data),
    .wr_cmd_i   (io_wr_i && sel_cmd),
    .rd_data_i  (io_rd_i && sel_data),
    .wdata_i    (io_wdata_i),
    .out_port_o (out_port),
    .obuf_o     (obuf),
    .obf_o      (obf),
    .ibf_o      (ibf),
    .kbd_en_o   (kbd_en_o)
  );

  assign a20_en_o = fast_q[EN_BIT] | out_port[EN_BIT];

  a20_addr_gate #(.AW(AW), .GATE_BIT(GATE_BIT)) u_gate (
    .addr_i (cpu_addr_i),
    .en_i   (a20_en_o),
    .addr_o (mem_addr_o)
  );

  always_comb begin
    status         = 8'h00;
    status[ST_OBF] = obf;
    status[ST_IBF] = ibf;
    status[ST_KBD] = kbd_en_o;
  end

  always_comb begin
    io_rdata_o = 8'h00;
    if (io_rd_i) begin
      if (sel_data)      io_rdata_o = obuf;
      else if (sel_cmd)  io_rdata_o = status;
      else if (sel_fast) io_rdata_o = fast_q;
    end
  end

  // R2
  gate_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a20_en_o |-> (mem_addr_o[GATE_BIT] == 1'b0));

  // R10
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> (io_rdata_o == 8'h00));

  // R3
  fast_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && sel_fast && io_wdata_i[EN_BIT]) |=> a20_en_o);
endmodule

// File: tb/a20_gate_ctrl_bench.sv
`timescale 1ns/1ps
module a20_gate_ctrl_bench;
  localparam int BUSY = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [23:0] cpu = 24'h0F_FFF0;
  logic [23:0] mem;
  logic        a20, kbd;

  int checks = 0, errors = 0;
  bit run = 0;

  // reference model state
  int m_fast, m_out, m_obuf, m_busy;
  bit m_obf, m_pend, m_kbd;

  always #2 clk = ~clk;

  a20_gate_ctrl u_a20_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .cpu_addr_i(cpu), .mem_addr_o(mem),
    .a20_en_o(a20), .kbd_en_o(kbd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_status();
    return (m_kbd ? 8'h10 : 0) | (m_busy != 0 ? 2 : 0) | (m_obf ? 1 : 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fast = 0; m_out = 0; m_obuf = 0; m_busy = 0;
      m_obf = 0; m_pend = 0; m_kbd = 1;
    end else begin
      bit acc;
      acc = wr && (addr == 16'h60 || addr == 16'h64) && m_busy == 0;
      if (rd && addr == 16'h60) m_obf = 0;
      if (m_busy > 0) m_busy--;
      if (wr && addr == 16'h92) m_fast = wdata;
      if (acc) begin
        m_busy = BUSY;
        if (addr == 16'h64) begin
          m_pend = (wdata == 8'hD1);
          if (wdata == 8'hD0) begin m_obuf = m_out; m_obf = 1; end
          if (wdata == 8'hAD) m_kbd = 0;
          if (wdata == 8'hAE) m_kbd = 1;
        end else begin
          if (m_pend) m_out = wdata;
          m_pend = 0;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (run) begin
      bit en;
      int er;
      en = ((m_fast >> 1) & 1) | ((m_out >> 1) & 1);
      chk("R4", a20, en);
      chk("R2", mem, en ? cpu : (cpu & 24'hEF_FFFF));
      chk("R7", kbd, m_kbd);
      er = 0;
      if (rd) begin
        if (addr == 16'h60) er = m_obuf;
        else if (addr == 16'h64) er = exp_status();
        else if (addr == 16'h92) er = m_fast;
      end
      chk("R10 rdata", rdata, er);
      cpu = cpu + 24'h12_3457;
    end
  end

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); #1; addr = a; wdata = d; wr = 1;
    @(negedge clk); #1; wr = 0;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); #1; addr = a; rd = 1;
    @(negedge clk); d = rdata; #1; rd = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 50; i++) begin
      io_rd(16'h64, s);
      if (!s[1]) break;
    end
  endtask

  initial begin
    logic [7:0] d;
    fork
      begin
        #1;
        chk("R1 gate", a20, 0);
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        run = 1;
        io_rd(16'h64, d); chk("R1 status", d, 8'h10);
        io_rd(16'h92, d); chk("R1 fast", d, 8'h00);
        chk("R1 kbd", kbd, 1);
        repeat (8) @(negedge clk);          // R2 closed-gate wrap
        io_wr(16'h92, 8'h02);               // R3
        io_rd(16'h92, d); chk("R3 readback", d, 8'h02);
        chk("R3 enable", a20, 1);
        repeat (8) @(negedge clk);
        io_wr(16'h92, 8'h00);
        chk("R3 disable", a20, 0);
        // R6 output-port write sequence
        io_wr(16'h64, 8'hD1); wait_idle();
        io_wr(16'h60, 8'h03); wait_idle();
        chk("R6 enable", a20, 1);
        io_wr(16'h92, 8'h02);               // R4 both on
        repeat (6) @(negedge clk);
        io_wr(16'h92, 8'h00);
        chk("R4 port only", a20, 1);
        // R5 read output port
        io_wr(16'h64, 8'hD0); wait_idle();
        io_rd(16'h64, d); chk("R5 obf set", d[0], 1);
        io_rd(16'h60, d); chk("R5 data", d, 8'h03);
        io_rd(16'h64, d); chk("R5 obf clear", d[0], 0);
        // R6 stray data write without D1
        io_wr(16'h60, 8'h00); wait_idle();
        chk("R6 stray", a20, 1);
        // R11 intervening command cancels D1
        io_wr(16'h64, 8'hD1); wait_idle();
        io_wr(16'h64, 8'hAD); wait_idle();
        chk("R7 off", kbd, 0);
        io_rd(16'h64, d); chk("R7 status", d[4], 0);
        io_wr(16'h60, 8'h00); wait_idle();
        chk("R11 cancel", a20, 1);
        io_wr(16'h64, 8'hAE); wait_idle();
        chk("R7 on", kbd, 1);
        // R8/R9 busy window and dropped writes
        io_wr(16'h64, 8'hD1);
        io_wr(16'h60, 8'h00);               // dropped, busy
        io_wr(16'h64, 8'hAD);               // dropped, busy
        chk("R9 kbd kept", kbd, 1);
        wait_idle();
        io_wr(16'h60, 8'h00); wait_idle();
        chk("R6 clear", a20, 0);
        io_wr(16'h64, 8'hAE);
        for (int i = 0; i < BUSY + 1; i++) begin
          io_rd(16'h64, d);                 // R8 per-cycle status via model
        end
        chk("R8 idle", d[1], 0);
        io_rd(16'h1234, d); chk("R10 unmapped", d, 0);
        repeat (4) @(negedge clk);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule